// File: doc/BRIEF.md
# Serial Port FIFO Register Front-End

This block is the register-side half of a synchronous serial port. It holds the transmit and receive FIFOs and the registers that software uses to reach them. It also drives the handshake toward the serial shifter. A single 32-bit data address serves both FIFOs. A write to that address queues a word for transmission. A read from it returns the oldest received word. A status register reports fill state, threshold crossings, frame activity and a sticky receive-overrun flag.

Three request lines go to the interrupt controller and the DMA engine:
- a transmit service request;
- a receive service request;
- an overrun indication.

Each line is the OR of its real FIFO condition and a bit in a test register. Software can therefore raise any of them on demand, even while the port is disabled. A fourth line, `irq`, combines all three.

Register accesses pass through a two-state bus machine:
- **BUS_IDLE**: `req_ready` is high. A request with `req_valid` takes the transition *accept* into BUS_ACK. Without a request the machine takes *hold* and stays in BUS_IDLE.
- **BUS_ACK**: `ack` is high for exactly one cycle, and `rdata` holds the read result captured at acceptance. The transition *complete* always returns to BUS_IDLE.

Top module: `serport_fifo_front`

## Requirements
- R1: A write accepted at offset 0x04 pushes the word into the transmit FIFO. The shifter receives transmit words in write order on `tx_data`, one per cycle in which `tx_valid` and `tx_ready` are both high. A read at 0x04 pops the receive FIFO and returns words in arrival order.
- R2: A write to 0x04 while the transmit FIFO holds DEPTH words is discarded and leaves the queued words unchanged.
- R3: A read at 0x04 while the receive FIFO is empty returns 0 and does not disturb the FIFO. The next word received is the next word read.
- R4: The status register is at 0x08 and resets to 0x104. Its bits are:
  - bit 2: transmit FIFO not full;
  - bit 3: receive FIFO not empty;
  - bit 4: busy, equal to `frame_active` while enabled and 0 while disabled;
  - bit 5: real transmit request;
  - bit 6: real receive request;
  - bit 7: overrun flag;
  - bit 8: transmit FIFO empty;
  - bit 9: receive FIFO full.
  All other bits read 0.
- R5: The control register is at 0x00 and resets to 0. Bit 0 is the port enable. The transmit threshold occupies bits 8 upward and the receive threshold bits 16 upward, each LVL_W bits wide. The register reads back only these fields.
- R6: The real transmit request is enable AND (transmit level <= transmit threshold). The real receive request is enable AND (receive level >= receive threshold) AND (receive FIFO not empty).
- R7: When the shifter delivers a word while the port is enabled and the receive FIFO is full, the word is discarded and the overrun flag is set. The flag stays set until software writes a 1 to status bit 7. Writing 0 there leaves it set.
- R8: The test register is at 0x0C and resets to 0. Bit 7 forces `overrun_irq`, bit 6 forces `rx_svc_req` and bit 5 forces `tx_svc_req`, whether or not the port is enabled. Only these three bits read back.
- R9: `irq` is the OR of `tx_svc_req`, `rx_svc_req` and `overrun_irq`.
- R10: While the port is disabled, `tx_valid` stays low and words offered on `rx_valid` are ignored.
- R11: `req_ready` is high only in BUS_IDLE. An accepted access is followed by exactly one cycle with `ack` high, and read data appears in that cycle. Unmapped offsets read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Register access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte offset of the register |
| req_wdata | input | 32 | Write data |
| req_ready | output | 1 | Bus machine can accept a request |
| ack | output | 1 | Access completed; read data valid |
| rdata | output | 32 | Read data |
| tx_valid | output | 1 | Transmit word available to the shifter |
| tx_data | output | 32 | Oldest transmit word |
| tx_ready | input | 1 | Shifter takes the transmit word |
| rx_valid | input | 1 | Shifter delivers a received word |
| rx_data | input | 32 | Received word |
| frame_active | input | 1 | Shifter is moving a frame |
| tx_svc_req | output | 1 | Transmit service request (interrupt/DMA) |
| rx_svc_req | output | 1 | Receive service request (interrupt/DMA) |
| overrun_irq | output | 1 | Receive overrun indication |
| irq | output | 1 | OR of the three request lines |

## Verification
The bench builds the block with DEPTH = 4 and ADDR_W = 8. With these values a full transmit FIFO, a full receive FIFO and an overrun are each reached within a handful of accesses. Thresholds of 1 and 2 sit strictly inside the fill range, so both threshold comparisons are seen on either side of the crossing. The three-bit threshold fields also make a write of all ones read back as a small known value, which exposes any stray control bits.

// File: rtl/serport_pkg.sv
package serport_pkg;
    localparam int DATA_W = 32;

    // Register offsets (byte addresses)
    localparam logic [7:0] OFS_CTRL = 8'h00;
    localparam logic [7:0] OFS_DATA = 8'h04;
    localparam logic [7:0] OFS_STAT = 8'h08;
    localparam logic [7:0] OFS_TEST = 8'h0C;

    // Status bit positions
    localparam int ST_TNF  = 2;
    localparam int ST_RNE  = 3;
    localparam int ST_BUSY = 4;
    localparam int ST_TREQ = 5;
    localparam int ST_RREQ = 6;
    localparam int ST_OVR  = 7;
    localparam int ST_TFE  = 8;
    localparam int ST_RFF  = 9;

    // Test register bit positions
    localparam int TB_TX  = 5;
    localparam int TB_RX  = 6;
    localparam int TB_OVR = 7;

    // Control field positions
    localparam int CT_EN    = 0;
    localparam int CT_TXTHR = 8;
    localparam int CT_RXTHR = 16;

    typedef enum logic [0:0] {BUS_IDLE, BUS_ACK} bus_state_e;
    typedef enum logic [2:0] {SEL_NONE, SEL_CTRL, SEL_DATA, SEL_STAT, SEL_TEST} reg_sel_e;
endpackage

// File: rtl/serport_fifo.sv
module serport_fifo #(
    parameter int WIDTH = 32,
    parameter int DEPTH = 16,
    localparam int LVL_W = $clog2(DEPTH + 1),
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] wdata,
    input  logic             pop,
    output logic [WIDTH-1:0] head,
    output logic             full,
    output logic             empty,
    output logic [LVL_W-1:0] level
);
    logic [WIDTH-1:0] mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [LVL_W-1:0] count;
    logic             do_push, do_pop;

    function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
    endfunction

    assign full    = (count == LVL_W'(DEPTH));
    assign empty   = (count == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign level   = count;
    assign head    = empty ? '0 : mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= ptr_next(wr_ptr);
            if (do_pop)  rd_ptr <= ptr_next(rd_ptr);
            unique case ({do_push, do_pop})
                2'b10:   count <= count + LVL_W'(1);
                2'b01:   count <= count - LVL_W'(1);
                default: count <= count;
            endcase
        end
    end

    // A push into a full FIFO changes nothing
    assert_full_drop_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !pop) |=> ($stable(count) && $stable(wr_ptr)));

    // A pop from an empty FIFO changes nothing
    assert_empty_pop_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && pop && !push) |=> ($stable(count) && $stable(rd_ptr)));

    assert_level_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        count <= LVL_W'(DEPTH));
endmodule

// File: rtl/serport_bus_fsm.sv
module serport_bus_fsm
    import serport_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] ctrl_val,
    input  logic [DATA_W-1:0] stat_val,
    input  logic [DATA_W-1:0] test_val,
    input  logic [DATA_W-1:0] data_val,
    output logic              req_ready,
    output logic              ack,
    output logic [DATA_W-1:0] rdata,
    output reg_sel_e          sel,
    output logic              wr_stb,
    output logic              rd_stb
);
    bus_state_e state_q, state_d;
    logic       accept;
    logic [DATA_W-1:0] rmux;

    always_comb begin
        if      (req_addr == ADDR_W'(OFS_CTRL)) sel = SEL_CTRL;
        else if (req_addr == ADDR_W'(OFS_DATA)) sel = SEL_DATA;
        else if (req_addr == ADDR_W'(OFS_STAT)) sel = SEL_STAT;
        else if (req_addr == ADDR_W'(OFS_TEST)) sel = SEL_TEST;
        else                                    sel = SEL_NONE;
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= BUS_IDLE;
        else        state_q <= state_d;
    end

    // Next state
    always_comb begin
        unique case (state_q)
            BUS_IDLE: state_d = req_valid ? BUS_ACK : BUS_IDLE; // accept / hold
            BUS_ACK:  state_d = BUS_IDLE;                        // complete
            default:  state_d = BUS_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        req_ready = (state_q == BUS_IDLE);
        ack       = (state_q == BUS_ACK);
        accept    = req_valid && req_ready;
        wr_stb    = accept && req_write;
        rd_stb    = accept && !req_write;
    end

    always_comb begin
        unique case (sel)
            SEL_CTRL: rmux = ctrl_val;
            SEL_DATA: rmux = data_val;
            SEL_STAT: rmux = stat_val;
            SEL_TEST: rmux = test_val;
            default:  rmux = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      rdata <= '0;
        else if (rd_stb) rdata <= rmux;
        else if (wr_stb) rdata <= '0;
    end

    assert_ack_follows_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (ack && !req_ready));

    assert_ack_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> !ack);
endmodule

// File: rtl/serport_fifo_front.sv
module serport_fifo_front
    import serport_pkg::*;
#(
    parameter int DEPTH  = 16,
    parameter int ADDR_W = 8,
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [31:0]       req_wdata,
    output logic              req_ready,
    output logic              ack,
    output logic [31:0]       rdata,
    output logic              tx_valid,
    output logic [31:0]       tx_data,
    input  logic              tx_ready,
    input  logic              rx_valid,
    input  logic [31:0]       rx_data,
    input  logic              frame_active,
    output logic              tx_svc_req,
    output logic              rx_svc_req,
    output logic              overrun_irq,
    output logic              irq
);
    logic             en_q, ovr_q;
    logic [LVL_W-1:0] txthr_q, rxthr_q;
    logic [2:0]       test_q;               // {ovr, rx, tx}
    reg_sel_e         sel;
    logic             wr_stb, rd_stb;
    logic             wr_ctrl, wr_stat, wr_test, wr_data, rd_data;
    logic             tx_full, tx_empty, rx_full, rx_empty;
    logic [LVL_W-1:0] tx_level, rx_level;
    logic [31:0]      rx_head, ctrl_val, stat_val, test_val;
    logic             tx_real, rx_real, ovr_set, ovr_clr, rx_push, tx_pop;

    assign wr_ctrl = wr_stb && (sel == SEL_CTRL);
    assign wr_stat = wr_stb && (sel == SEL_STAT);
    assign wr_test = wr_stb && (sel == SEL_TEST);
    assign wr_data = wr_stb && (sel == SEL_DATA);
    assign rd_data = rd_stb && (sel == SEL_DATA);

    serport_bus_fsm #(.ADDR_W(ADDR_W)) u_bus (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .ctrl_val(ctrl_val), .stat_val(stat_val), .test_val(test_val), .data_val(rx_head),
        .req_ready(req_ready), .ack(ack), .rdata(rdata),
        .sel(sel), .wr_stb(wr_stb), .rd_stb(rd_stb)
    );

    assign tx_valid = en_q && !tx_empty;
    assign tx_pop   = tx_valid && tx_ready;

    serport_fifo #(.WIDTH(DATA_W), .DEPTH(DEPTH)) u_txf (
        .clk(clk), .rst_n(rst_n),
        .push(wr_data), .wdata(req_wdata), .pop(tx_pop),
        .head(tx_data), .full(tx_full), .empty(tx_empty), .level(tx_level)
    );

    assign rx_push = rx_valid && en_q;

    serport_fifo #(.WIDTH(DATA_W), .DEPTH(DEPTH)) u_rxf (
        .clk(clk), .rst_n(rst_n),
        .push(rx_push), .wdata(rx_data), .pop(rd_data),
        .head(rx_head), .full(rx_full), .empty(rx_empty), .level(rx_level)
    );

    // Configuration and test registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q    <= 1'b0;
            txthr_q <= '0;
            rxthr_q <= '0;
            test_q  <= '0;
        end else begin
            if (wr_ctrl) begin
                en_q    <= req_wdata[CT_EN];
                txthr_q <= req_wdata[CT_TXTHR +: LVL_W];
                rxthr_q <= req_wdata[CT_RXTHR +: LVL_W];
            end
            if (wr_test) test_q <= req_wdata[TB_OVR:TB_TX];
        end
    end

    // Sticky overrun; a new overrun wins over a simultaneous clear
    assign ovr_set = rx_push && rx_full;
    assign ovr_clr = wr_stat && req_wdata[ST_OVR];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       ovr_q <= 1'b0;
        else if (ovr_set) ovr_q <= 1'b1;
        else if (ovr_clr) ovr_q <= 1'b0;
    end

    assign tx_real = en_q && (tx_level <= txthr_q);
    assign rx_real = en_q && !rx_empty && (rx_level >= rxthr_q);

    always_comb begin
        ctrl_val = '0;
        ctrl_val[CT_EN]            = en_q;
        ctrl_val[CT_TXTHR +: LVL_W] = txthr_q;
        ctrl_val[CT_RXTHR +: LVL_W] = rxthr_q;

        test_val = '0;
        test_val[TB_OVR:TB_TX] = test_q;

        stat_val = '0;
        stat_val[ST_TNF]  = !tx_full;
        stat_val[ST_RNE]  = !rx_empty;
        stat_val[ST_BUSY] = en_q && frame_active;
        stat_val[ST_TREQ] = tx_real;
        stat_val[ST_RREQ] = rx_real;
        stat_val[ST_OVR]  = ovr_q;
        stat_val[ST_TFE]  = tx_empty;
        stat_val[ST_RFF]  = rx_full;
    end

    assign tx_svc_req  = tx_real || test_q[0];
    assign rx_svc_req  = rx_real || test_q[1];
    assign overrun_irq = ovr_q   || test_q[2];
    assign irq         = tx_svc_req || rx_svc_req || overrun_irq;

    assert_ovr_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr_q && !ovr_clr) |=> ovr_q);

    assert_ovr_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && en_q && rx_full) |=> ovr_q);

    assert_disabled_rx_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_q && rx_valid && !rd_data) |=> $stable(rx_level));

    assert_tx_drain_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && tx_ready && !wr_data) |=> (tx_level == $past(tx_level) - LVL_W'(1)));
endmodule

// File: tb/tb_serport_fifo_front.sv
`timescale 1ns/1ps
module tb_serport_fifo_front;
    localparam int DEPTH = 4;
    localparam int AW    = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0, req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [31:0]   req_wdata = '0;
    logic          req_ready, ack;
    logic [31:0]   rdata;
    logic          tx_valid;
    logic [31:0]   tx_data;
    logic          tx_ready = 1'b0;
    logic          rx_valid = 1'b0;
    logic [31:0]   rx_data = '0;
    logic          frame_active = 1'b0;
    logic          tx_svc_req, rx_svc_req, overrun_irq, irq;

    int n_chk = 0, n_fail = 0, tx_seen = 0;
    logic [31:0] txq[$];
    logic [31:0] rxq[$];
    logic [31:0] r;

    always #2.5 clk = ~clk;

    serport_fifo_front #(.DEPTH(DEPTH), .ADDR_W(AW)) dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .req_ready(req_ready), .ack(ack), .rdata(rdata),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
        .rx_valid(rx_valid), .rx_data(rx_data), .frame_active(frame_active),
        .tx_svc_req(tx_svc_req), .rx_svc_req(rx_svc_req), .overrun_irq(overrun_irq), .irq(irq)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus(input bit wr, input logic [7:0] a, input logic [31:0] d, output logic [31:0] res);
        @(posedge clk); #1;
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
        @(posedge clk); #1;
        req_valid = 1'b0;
        @(negedge clk);
        chk(ack === 1'b1, "R11 ack", {31'b0, ack}, 32'd1);
        res = rdata;
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        logic [31:0] junk;
        bus(1'b1, a, d, junk);
    endtask

    task automatic rd_expect(input logic [7:0] a, input logic [31:0] exp, input string req);
        logic [31:0] v;
        bus(1'b0, a, 32'h0, v);
        chk(v === exp, req, v, exp);
    endtask

    // Driver: queue a transmit word and record it when it should be accepted
    task automatic tx_put(input logic [31:0] d, input bit accepted);
        wr(8'h04, d);
        if (accepted) txq.push_back(d);
    endtask

    // Driver: shifter delivers a received word
    task automatic rx_put(input logic [31:0] d, input bit kept);
        @(posedge clk); #1;
        rx_valid = 1'b1; rx_data = d;
        @(posedge clk); #1;
        rx_valid = 1'b0;
        if (kept) rxq.push_back(d);
    endtask

    task automatic rx_read(input string req);
        logic [31:0] exp;
        exp = (rxq.size() != 0) ? rxq.pop_front() : 32'h0;
        rd_expect(8'h04, exp, req);
    endtask

    // Monitor: transmit words leave in the order they were written
    always @(negedge clk) begin
        if (rst_n && tx_valid && tx_ready) begin
            tx_seen++;
            if (txq.size() == 0) chk(1'b0, "R1 unexpected tx word", tx_data, 32'h0);
            else begin
                logic [31:0] e;
                e = txq.pop_front();
                chk(tx_data === e, "R1 tx order", tx_data, e);
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // Reset state
        chk(req_ready === 1'b1 && ack === 1'b0, "R11 reset bus", {30'b0, req_ready, ack}, 32'h2);
        chk(irq === 1'b0 && tx_valid === 1'b0, "R9 reset outputs", {30'b0, irq, tx_valid}, 32'h0);
        rd_expect(8'h08, 32'h104, "R4 status reset");
        rd_expect(8'h00, 32'h0, "R5 ctrl reset");
        rd_expect(8'h0C, 32'h0, "R8 test reset");
        rd_expect(8'h10, 32'h0, "R11 unmapped read");
        wr(8'h10, 32'hFFFF_FFFF);
        rd_expect(8'h00, 32'h0, "R11 unmapped write ignored");
        chk(tx_svc_req === 1'b0, "R6 no tx request while disabled", {31'b0, tx_svc_req}, 32'h0);

        // Control field readback
        wr(8'h00, 32'hFFFF_FFFE);
        rd_expect(8'h00, 32'h0007_0700, "R5 ctrl fields only");
        wr(8'h00, 32'h0);

        // Test register while disabled
        wr(8'h0C, 32'h20);
        @(negedge clk);
        chk(tx_svc_req === 1'b1 && rx_svc_req === 1'b0 && irq === 1'b1, "R8 force tx",
            {29'b0, tx_svc_req, rx_svc_req, irq}, 32'h5);
        wr(8'h0C, 32'h40);
        @(negedge clk);
        chk(rx_svc_req === 1'b1 && tx_svc_req === 1'b0, "R8 force rx", {30'b0, rx_svc_req, tx_svc_req}, 32'h2);
        wr(8'h0C, 32'h80);
        @(negedge clk);
        chk(overrun_irq === 1'b1 && irq === 1'b1, "R9 force overrun", {30'b0, overrun_irq, irq}, 32'h3);
        wr(8'h0C, 32'hFFFF_FFFF);
        rd_expect(8'h0C, 32'hE0, "R8 readback mask");
        wr(8'h0C, 32'h0);
        @(negedge clk);
        chk(irq === 1'b0, "R9 all clear", {31'b0, irq}, 32'h0);

        // Fill transmit FIFO while disabled
        tx_ready = 1'b1;
        for (int i = 0; i < DEPTH; i++) tx_put(32'hA000_0000 + i, 1'b1);
        tx_put(32'hDEAD_BEEF, 1'b0);          // R2: dropped
        repeat (3) begin
            @(negedge clk);
            chk(tx_valid === 1'b0, "R10 tx held while disabled", {31'b0, tx_valid}, 32'h0);
        end
        rd_expect(8'h08, 32'h000, "R4 tx full status");
        tx_ready = 1'b0;
        wr(8'h00, 32'h0002_0101);             // enable, tx thr 1, rx thr 2
        @(negedge clk);
        chk(tx_svc_req === 1'b0, "R6 tx above threshold", {31'b0, tx_svc_req}, 32'h0);
        tx_ready = 1'b1;
        repeat (10) @(posedge clk);
        #1 tx_ready = 1'b0;
        @(negedge clk);
        chk(tx_seen == DEPTH && txq.size() == 0, "R2 only queued words sent", tx_seen, DEPTH);
        chk(tx_svc_req === 1'b1, "R6 tx at threshold", {31'b0, tx_svc_req}, 32'h1);
        rd_expect(8'h08, 32'h124, "R4 tx empty status");

        // Receive path with threshold 2
        rx_put(32'h1111_0001, 1'b1);
        @(negedge clk);
        chk(rx_svc_req === 1'b0, "R6 rx below threshold", {31'b0, rx_svc_req}, 32'h0);
        rd_expect(8'h08, 32'h12C, "R4 rx not empty");
        rx_put(32'h1111_0002, 1'b1);
        @(negedge clk);
        chk(rx_svc_req === 1'b1, "R6 rx at threshold", {31'b0, rx_svc_req}, 32'h1);
        rx_read("R1 rx first");
        rx_read("R1 rx second");
        rx_read("R3 empty read zero");
        rd_expect(8'h08, 32'h124, "R3 empty after read");
        rx_put(32'h2222_0003, 1'b1);
        rx_read("R3 fifo intact after empty read");

        // Overrun
        for (int i = 0; i < DEPTH; i++) rx_put(32'h3300_0000 + i, 1'b1);
        rx_put(32'h3300_00FF, 1'b0);
        @(negedge clk);
        chk(overrun_irq === 1'b1 && irq === 1'b1, "R7 overrun raised", {30'b0, overrun_irq, irq}, 32'h3);
        rd_expect(8'h08, 32'h3EC, "R4 R7 full and overrun status");
        for (int i = 0; i < DEPTH; i++) rx_read("R7 kept words");
        rx_read("R7 extra word discarded");
        wr(8'h08, 32'h0);
        @(negedge clk);
        chk(overrun_irq === 1'b1, "R7 sticky after write 0", {31'b0, overrun_irq}, 32'h1);
        wr(8'h08, 32'h80);
        @(negedge clk);
        chk(overrun_irq === 1'b0, "R7 cleared by write 1", {31'b0, overrun_irq}, 32'h0);

        // Busy
        frame_active = 1'b1;
        rd_expect(8'h08, 32'h134, "R4 busy while enabled");
        wr(8'h00, 32'h0002_0100);             // disable
        rd_expect(8'h08, 32'h104, "R4 busy low while disabled");

        // Receive ignored while disabled
        rx_put(32'h4444_0004, 1'b0);
        rd_expect(8'h08, 32'h104, "R10 rx ignored");
        rx_read("R10 nothing to read");
        frame_active = 1'b0;

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule